// File: doc/BRIEF.md
# Code Prefetch Queue and Bus Sequencer

This block sits between the execution side of a small processor and a single 8-bit external bus. It reads code bytes ahead of the execution point into a four-entry queue, and the execution side takes them from that queue in order. The same bus also carries the execution side's own data transfers to memory or I/O space. Those transfers take priority over prefetch. A code fetch starts only when the execution side is not asking for the bus and the queue is not full.

Every bus transfer is a sequence of at least four clocks (T1 to T4). The sequencer adds wait clocks in T3 in two cases. A fixed number is added for each address space: none for memory and one for I/O by default. One more clock is added for each clock in which the external ready input is low. A flush input handles a change of program flow. It empties the queue, loads a new fetch address and throws away the byte of any code fetch still running. That fetch is never cut short. Status outputs give the queue level, a bus-busy flag and the kind of the current bus cycle.

Reset is asynchronous and active low. Its release is expected to be synchronised to the clock outside this block.

Top module: `code_prefetch_biu`

## Requirements
- R1: While reset is held, `q_level` is 0, `pop_valid`, `bus_busy`, `bus_rd`, `bus_wr` and `xdone` are 0, and `bus_kind` is 0 (idle).
- R2: A code fetch is started only when fewer than 4 bytes will be held after the current clock. With no pops, the queue fills to exactly 4 and the bus then stays idle.
- R3: The first code fetch after a flush reads `flush_addr`. Each completed fetch adds one to the fetch address. Bytes come out on `pop_byte` in fetch order, each equal to the bus data read for it.
- R4: A code fetch or memory cycle with `bus_ready` high lasts exactly 4 clocks. Back-to-back code fetches follow each other with no idle clock, so the queue level rises every 4 clocks.
- R5: An I/O cycle with `bus_ready` high lasts exactly 5 clocks (one forced wait) and drives `bus_io` high.
- R6: Each clock in which `bus_ready` is low while the cycle sits in T3 (third clock onward, after any forced waits) stretches the cycle by one clock.
- R7: When an execution request and a prefetch both want a free bus, the execution transfer wins. A fetch already running finishes, and its byte is enqueued, before a pending execution transfer starts in the very next clock.
- R8: `xdone` is high only during the last clock of an execution transfer. In that clock `bus_addr` equals `xaddr`, `bus_wr` equals `xwr`, `bus_wdata` holds the write data, and `xrdata` carries the read byte.
- R9: One clock after `flush`, `q_level` is 0. A fetch in flight keeps running to its end, but its byte is dropped.
- R10: `pop_valid` is low while the queue is empty, and a pop is taken only when it is high. After a flush with the bus idle, the first byte becomes available 6 clocks after the flush edge.
- R11: `bus_kind` encodes the cycle kind as 0 idle, 1 code fetch, 2 memory, 3 I/O, and `bus_busy` is high exactly while `bus_kind` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and reload the fetch address |
| flush_addr | input | 16 | New fetch address taken with `flush` |
| pop_req | input | 1 | Execution side takes a code byte |
| pop_valid | output | 1 | A code byte is available |
| pop_byte | output | 8 | Oldest queued code byte |
| xreq | input | 1 | Execution data transfer request, held until `xdone` |
| xio | input | 1 | Transfer targets I/O space (1) or memory (0) |
| xwr | input | 1 | Transfer is a write (1) or read (0) |
| xaddr | input | 16 | Transfer address |
| xwdata | input | 8 | Write data |
| xdone | output | 1 | Last clock of the execution transfer |
| xrdata | output | 8 | Read data, valid with `xdone` |
| bus_addr | output | 16 | Bus address of the current or last cycle |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| bus_ready | input | 1 | Device ready; low in T3 inserts a wait clock |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| bus_io | output | 1 | Cycle targets I/O space |
| q_level | output | 3 | Number of queued code bytes |
| bus_busy | output | 1 | A bus cycle is in progress |
| bus_kind | output | 2 | Current cycle kind (0 idle, 1 fetch, 2 memory, 3 I/O) |

## Verification
Each cycle begins on the clock edge after its grant, so a transfer shows its kind at the first falling edge after that grant. `xdone` is seen at the falling edge of its last clock, 3 clocks after the first one for memory, 4 for I/O, plus one for each ready-low clock in T3. A fetched byte becomes visible one clock after its fetch's last clock. After a flush from an idle bus, the level therefore changes at falling edges 6, 10, 14 and 18, and after a flush in the middle of a fetch the first byte appears at edge 7. The bench counts falling edges from the stimulus and compares at exactly those edges. Popped bytes are checked against a queue of expected bytes that is filled when each flush is issued.

// File: rtl/biu_pkg.sv
package biu_pkg;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_FETCH = 2'd1,
    BK_MEM   = 2'd2,
    BK_IO    = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    TS_1 = 2'd0,
    TS_2 = 2'd1,
    TS_3 = 2'd2,
    TS_4 = 2'd3
  } tstate_e;

endpackage

// File: rtl/biu_code_queue.sv
module biu_code_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_nx = count_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_nx = '0;
    end else begin
      if (wr_en) wr_ptr_d = bump(wr_ptr_q);
      if (rd_en) rd_ptr_d = bump(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   count_nx = count_q + CW'(1);
        2'b01:   count_nx = count_q - CW'(1);
        default: count_nx = count_q;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_nx;
    end
  end

  // storage, written only with its enable
  always_ff @(posedge clk) begin
    if (wr_en && !clr) slot_q[wr_ptr_q] <= wr_data;
  end

  assign rd_data = slot_q[rd_ptr_q];
  assign count   = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clr) |-> (count_q < CW'(DEPTH))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count_q != '0)); // R10

endmodule

// File: rtl/biu_bus_seq.sv
module biu_bus_seq
  import biu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MEM_WAITS = 0,
  parameter int IO_WAITS  = 1,
  localparam int MAXW     = (IO_WAITS > MEM_WAITS) ? IO_WAITS : MEM_WAITS,
  localparam int WW       = $clog2(MAXW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  bus_kind_e     start_kind,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          last,
  output bus_kind_e     kind,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io
);

  bus_kind_e     kind_q, kind_d;
  tstate_e       ts_q, ts_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          load_en;

  assign busy    = (kind_q != BK_IDLE);
  assign last    = busy && (ts_q == TS_4);
  assign load_en = start && (!busy || last);

  // next-state
  always_comb begin
    kind_d = kind_q;
    ts_d   = ts_q;
    wcnt_d = wcnt_q;
    wr_d   = wr_q;
    if (busy) begin
      case (ts_q)
        TS_1: ts_d = TS_2;
        TS_2: ts_d = TS_3;
        TS_3: begin
          if (wcnt_q != '0)   wcnt_d = wcnt_q - WW'(1);
          else if (bus_ready) ts_d   = TS_4;
        end
        default: begin
          kind_d = BK_IDLE;
          ts_d   = TS_1;
          wr_d   = 1'b0;
        end
      endcase
    end
    if (load_en) begin
      kind_d = start_kind;
      ts_d   = TS_1;
      wcnt_d = (start_kind == BK_IO) ? WW'(IO_WAITS) : WW'(MEM_WAITS);
      wr_d   = start_wr;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= BK_IDLE;
      ts_q   <= TS_1;
      wcnt_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      kind_q <= kind_d;
      ts_q   <= ts_d;
      wcnt_q <= wcnt_d;
      wr_q   <= wr_d;
    end
  end

  // address and data held from the start of a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end
  end

  assign kind      = kind_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_rd    = busy && !wr_q;
  assign bus_wr    = busy && wr_q;
  assign bus_io    = (kind_q == BK_IO);

  AST_MIN_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> ($past(busy) && $past(busy, 2) && $past(busy, 3))); // R4
  AST_FORCED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ts_q == TS_3 && wcnt_q != '0) |=> (ts_q == TS_3)); // R5
  AST_NOTREADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ts_q == TS_3 && !bus_ready) |=> (ts_q == TS_3)); // R6
  AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy || last)); // R7

endmodule

// File: rtl/biu_arbiter.sv
module biu_arbiter
  import biu_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          free,
  input  logic          exec_ending,
  input  logic          xreq,
  input  logic          xio,
  input  logic          flush,
  input  logic [CW-1:0] level_nx,
  output logic          start,
  output logic          sel_exec,
  output bus_kind_e     start_kind
);

  logic xwant;
  logic fetch_ok;

  // a request still high in its own last clock is already served
  assign xwant    = xreq && !exec_ending;
  assign fetch_ok = !flush && (level_nx < CW'(DEPTH));

  always_comb begin
    start      = 1'b0;
    sel_exec   = 1'b0;
    start_kind = BK_IDLE;
    if (free && xwant) begin
      start      = 1'b1;
      sel_exec   = 1'b1;
      start_kind = xio ? BK_IO : BK_MEM;
    end else if (free && fetch_ok) begin
      start      = 1'b1;
      start_kind = BK_FETCH;
    end
  end

endmodule

// File: rtl/code_prefetch_biu.sv
module code_prefetch_biu
  import biu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int DEPTH     = 4,
  parameter int MEM_WAITS = 0,
  parameter int IO_WAITS  = 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic [DW-1:0] pop_byte,
  input  logic          xreq,
  input  logic          xio,
  input  logic          xwr,
  input  logic [AW-1:0] xaddr,
  input  logic [DW-1:0] xwdata,
  output logic          xdone,
  output logic [DW-1:0] xrdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [CW-1:0] q_level,
  output logic          bus_busy,
  output logic [1:0]    bus_kind
);

  logic          busy, last, free;
  bus_kind_e     kind;
  logic          start, sel_exec;
  bus_kind_e     start_kind;
  logic          exec_ending, fetch_end;
  logic          q_wr, q_rd;
  logic [CW-1:0] q_count, q_count_nx;
  logic [AW-1:0] fa_q, fa_d;
  logic          cancel_q, cancel_d;
  logic [AW-1:0] start_addr;

  assign free        = !busy || last;
  assign exec_ending = last && (kind == BK_MEM || kind == BK_IO);
  assign fetch_end   = last && (kind == BK_FETCH);
  assign q_wr        = fetch_end && !cancel_q && !flush;
  assign q_rd        = pop_req && (q_count != '0) && !flush;

  // fetch pointer and cancel flag next-state
  always_comb begin
    fa_d = fa_q;
    if (flush)     fa_d = flush_addr;
    else if (q_wr) fa_d = fa_q + AW'(1);
    cancel_d = cancel_q;
    if (start)                               cancel_d = 1'b0;
    else if (flush && kind == BK_FETCH)      cancel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q     <= '0;
      cancel_q <= 1'b0;
    end else begin
      fa_q     <= fa_d;
      cancel_q <= cancel_d;
    end
  end

  // a back-to-back fetch must use the already advanced pointer
  assign start_addr = sel_exec ? xaddr : fa_d;

  biu_code_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush),
    .wr_en    (q_wr),
    .wr_data  (bus_rdata),
    .rd_en    (q_rd),
    .rd_data  (pop_byte),
    .count    (q_count),
    .count_nx (q_count_nx)
  );

  biu_arbiter #(.DEPTH(DEPTH)) u_arb (
    .free        (free),
    .exec_ending (exec_ending),
    .xreq        (xreq),
    .xio         (xio),
    .flush       (flush),
    .level_nx    (q_count_nx),
    .start       (start),
    .sel_exec    (sel_exec),
    .start_kind  (start_kind)
  );

  biu_bus_seq #(
    .AW(AW), .DW(DW), .MEM_WAITS(MEM_WAITS), .IO_WAITS(IO_WAITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_kind  (start_kind),
    .start_wr    (sel_exec && xwr),
    .start_addr  (start_addr),
    .start_wdata (xwdata),
    .bus_ready   (bus_ready),
    .busy        (busy),
    .last        (last),
    .kind        (kind),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_io      (bus_io)
  );

  assign pop_valid = (q_count != '0);
  assign xdone     = exec_ending;
  assign xrdata    = bus_rdata;
  assign q_level   = q_count;
  assign bus_busy  = busy;
  assign bus_kind  = kind;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_level == '0)); // R9
  AST_EXEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (free && xreq && !exec_ending) |-> (start && start_kind != BK_FETCH)); // R7
  AST_XDONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xdone |=> !xdone); // R8
  AST_KIND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy == (bus_kind != 2'd0)); // R11

endmodule

// File: tb/tb_code_prefetch_biu.sv
module tb_code_prefetch_biu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [15:0] flush_addr;
  logic        pop_req;
  logic        pop_valid;
  logic [7:0]  pop_byte;
  logic        xreq, xio, xwr;
  logic [15:0] xaddr;
  logic [7:0]  xwdata;
  logic        xdone;
  logic [7:0]  xrdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_ready;
  logic        bus_rd, bus_wr, bus_io;
  logic [2:0]  q_level;
  logic        bus_busy;
  logic [1:0]  bus_kind;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_f(bus_addr);

  code_prefetch_biu dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_byte(pop_byte),
    .xreq(xreq), .xio(xio), .xwr(xwr), .xaddr(xaddr), .xwdata(xwdata),
    .xdone(xdone), .xrdata(xrdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_io(bus_io), .q_level(q_level),
    .bus_busy(bus_busy), .bus_kind(bus_kind)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // driver side of the scoreboard: expected code stream from an address
  task automatic expect_from(input logic [15:0] a);
    exp_q.delete();
    for (int i = 0; i < 32; i++) exp_q.push_back(mem_f(a + 16'(i)));
  endtask

  // monitor side: every accepted pop is compared with the next expected byte
  always @(negedge clk) begin
    #1;
    if (rst_n && pop_req && pop_valid && !flush) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 pop with nothing expected", pop_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(pop_byte == e, "R3 popped byte order", pop_byte, e);
      end
    end
  end

  task automatic flush_to(input logic [15:0] a);
    @(negedge clk);
    flush = 1'b1;
    flush_addr = a;
    expect_from(a);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic wait_full();
    while (!(q_level == 3'd4 && !bus_busy)) @(negedge clk);
  endtask

  task automatic pop_n(input int n);
    int k = 0;
    @(negedge clk);
    pop_req = 1'b1;
    while (1) begin
      if (pop_valid) k++;
      if (k == n) break;
      @(negedge clk);
    end
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic xfer(input bit nowait, input bit io, input bit wr,
                      input logic [15:0] a, input logic [7:0] wd, input int k,
                      input int exp_len, input string tag,
                      output int prev_k, output int lvl0);
    int rel = -1;
    int pk = 0;
    prev_k = -1;
    lvl0 = -1;
    if (!nowait) @(negedge clk);
    xreq = 1'b1; xio = io; xwr = wr; xaddr = a; xwdata = wd;
    while (1) begin
      if (rel < 0 && bus_kind >= 2'd2) begin
        rel = 0; prev_k = pk; lvl0 = int'(q_level);
      end
      if (rel >= 0) bus_ready = !(rel >= 2 && rel < 2 + k);
      if (xdone) begin
        chk(rel + 1 == exp_len, tag, rel + 1, exp_len);
        chk(bus_addr == a, "R8 bus_addr at xdone", bus_addr, a);
        chk(bus_wr == wr, "R8 bus_wr at xdone", bus_wr, wr);
        if (wr) chk(bus_wdata == wd, "R8 bus_wdata", bus_wdata, wd);
        else    chk(xrdata == mem_f(a), "R8 xrdata", xrdata, mem_f(a));
        chk(bus_kind == (io ? 2'd3 : 2'd2), "R11 bus_kind of transfer", bus_kind, io ? 3 : 2);
        chk(bus_io == io, "R5 bus_io", bus_io, io);
        xreq = 1'b0;
        bus_ready = 1'b1;
        break;
      end
      pk = int'(bus_kind);
      if (rel >= 0) rel++;
      @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pk, lv, n, lastlvl;
    int t[5];
    rst_n = 1'b0; flush = 1'b0; flush_addr = '0; pop_req = 1'b0;
    xreq = 1'b0; xio = 1'b0; xwr = 1'b0; xaddr = '0; xwdata = '0; bus_ready = 1'b1;
    expect_from(16'h0000);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(q_level == 0, "R1 q_level", q_level, 0);
    chk(pop_valid == 0, "R1 pop_valid", pop_valid, 0);
    chk(bus_busy == 0, "R1 bus_busy", bus_busy, 0);
    chk(bus_kind == 0, "R1 bus_kind", bus_kind, 0);
    chk(bus_rd == 0 && bus_wr == 0, "R1 bus strobes", {bus_rd, bus_wr}, 0);
    chk(xdone == 0, "R1 xdone", xdone, 0);
    rst_n = 1'b1;

    // R2 fill to four then stay idle; R3 addresses from zero
    wait_full();
    repeat (6) @(negedge clk);
    chk(q_level == 4, "R2 queue stops at four", q_level, 4);
    chk(bus_busy == 0, "R2 bus idle when full", bus_busy, 0);
    chk(bus_addr == 16'h0003, "R3 last fetch address", bus_addr, 16'h0003);

    // R4 R10 flush from idle: levels rise at edges 6,10,14,18
    flush_to(16'h0100);
    n = 1; lastlvl = 0;
    for (int i = 0; i < 5; i++) t[i] = 0;
    while (n < 40) begin
      if (n == 1) chk(q_level == 0, "R9 level after flush", q_level, 0);
      if (n == 2) begin
        chk(bus_kind == 2'd1 && bus_busy, "R11 fetch kind", bus_kind, 1);
        chk(bus_addr == 16'h0100, "R3 first fetch at flush address", bus_addr, 16'h0100);
      end
      if (n == 5) chk(pop_valid == 0, "R10 empty until fetch ends", pop_valid, 0);
      if (int'(q_level) != lastlvl) begin
        lastlvl = int'(q_level);
        t[lastlvl] = n;
      end
      if (q_level == 3'd4) break;
      @(negedge clk);
      n++;
    end
    chk(t[1] == 6, "R10 first byte six clocks after flush", t[1], 6);
    chk(t[2] - t[1] == 4, "R4 fetch length", t[2] - t[1], 4);
    chk(t[3] - t[2] == 4, "R4 back-to-back fetch", t[3] - t[2], 4);
    chk(t[4] - t[3] == 4, "R4 back-to-back fetch", t[4] - t[3], 4);

    // R3 stream order through the scoreboard
    pop_n(6);
    wait_full();

    // R4 R8 memory read and write
    xfer(1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 0, 4, "R4 memory read length", pk, lv);
    xfer(1'b0, 1'b0, 1'b1, 16'h2000, 8'h3C, 0, 4, "R4 memory write length", pk, lv);
    // R5 I/O read and write
    xfer(1'b0, 1'b1, 1'b0, 16'h0060, 8'h00, 0, 5, "R5 io read length", pk, lv);
    xfer(1'b0, 1'b1, 1'b1, 16'h0061, 8'hA7, 0, 5, "R5 io write length", pk, lv);
    // R6 not-ready stretching
    xfer(1'b0, 1'b0, 1'b0, 16'h0B00, 8'h00, 3, 7, "R6 three not-ready clocks", pk, lv);
    xfer(1'b0, 1'b0, 1'b0, 16'h0B01, 8'h00, 1, 5, "R6 one not-ready clock", pk, lv);

    // R7 request during a running fetch: fetch finishes, transfer follows at once
    wait_full();
    pop_n(1);
    xfer(1'b0, 1'b0, 1'b0, 16'h0C00, 8'h00, 0, 4, "R7 transfer after fetch", pk, lv);
    chk(pk == 1, "R7 no idle clock after fetch", pk, 1);
    chk(lv == 4, "R7 running fetch completed", lv, 4);

    // R7 both want an idle bus: transfer wins over prefetch
    wait_full();
    @(negedge clk);
    flush = 1'b1; flush_addr = 16'h0200; expect_from(16'h0200);
    @(negedge clk);
    flush = 1'b0;
    xfer(1'b1, 1'b0, 1'b0, 16'h0D00, 8'h00, 0, 4, "R7 transfer length", pk, lv);
    chk(pk == 0, "R7 transfer starts first on idle bus", pk, 0);
    chk(lv == 0, "R7 prefetch waited", lv, 0);
    pop_n(2);

    // R9 flush during a fetch: fetch not aborted, its byte dropped
    wait_full();
    pop_n(1);
    flush_to(16'h0300);
    n = 1;
    chk(q_level == 0, "R9 level after flush in fetch", q_level, 0);
    chk(bus_kind == 2'd1, "R9 fetch keeps running", bus_kind, 1);
    while (!pop_valid && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 3) chk(bus_addr == 16'h0300, "R9 next fetch at new address", bus_addr, 16'h0300);
    end
    chk(n == 7, "R9 dropped byte not enqueued", n, 7);
    pop_n(3);
    wait_full();
    chk(q_level == 4, "R2 refilled", q_level, 4);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule